// File: doc/BRIEF.md
# One-Wire Byte Write Slot Sequencer

This block is the master-side timing engine for a single open-drain one-wire line. A host register front end presents a command code and a data byte. When the code is the write-byte code and the engine is idle, the engine accepts the byte and plays it onto the line as eight back-to-back time slots, least-significant bit first. Every slot starts with the line pulled low. The low phase is short for a 1 and long for a 0, and the line is released for the rest of the slot so that it can recover before the next slot begins.

The same waveform serves for reading. A 1 slot is also a read slot: a slave answering 0 holds the line low past the fixed sample instant, and a slave answering 1 does not. The engine takes the line level at that instant in every slot, passes it through a two-stage synchronizer, and shifts it into a receive byte. The receive byte is complete when busy drops.

A busy flag covers the whole eight-slot transfer and gives the host something to poll. A write-byte command that arrives while busy is neither acknowledged nor acted on. A speed-select input is latched when a command is accepted, and it selects between a standard and a fast set of slot timings. All durations are counts of the system clock.

Top module: `ow_byte_slot_engine`

## Requirements
- R1: While reset is asserted and in the first cycle after it, drive_low, busy, done and cmd_ack are 0 and rx_byte is 8'h00.
- R2: cmd_ack is high in the same cycle as the input only when cmd_valid is 1, cmd_code is 8'hA5 and busy is 0. On the following clock edge busy rises and drive_low goes high, which opens slot 0.
- R3: Once a command is accepted, busy stays high for exactly 8 × SLOT clock cycles, where SLOT is the slot length of the speed latched for that transfer.
- R4: Slot k (k = 0..7) carries bit k of the accepted data byte, so the byte goes out least-significant bit first.
- R5: A 0 bit holds drive_low high for the first LOW0 cycles of its slot and low for the remaining SLOT − LOW0 recovery cycles. drive_low is 0 whenever busy is 0.
- R6: A 1 bit holds drive_low high only for the first LOW1 cycles of its slot.
- R7: In every slot the engine samples the synchronized line at slot count SAMP. Because of the two-stage synchronizer, the value taken is the raw line_in level at count SAMP − 2. The value is shifted into rx_byte from the top, so slot k's sample ends up in rx_byte[k]. While the engine is idle, rx_byte does not change.
- R8: A write-byte command that arrives while busy is 1 gets no cmd_ack and has no effect on the running transfer, its timing, or the received byte.
- R9: A command whose code is not 8'hA5 gets no cmd_ack and starts nothing, even when the engine is idle.
- R10: fast_mode = 1 at acceptance selects the fast timing set (SLOT_FAST, LOW0_FAST, LOW1_FAST, SAMP_FAST) for the whole transfer. fast_mode = 0 selects the standard set. Later changes of fast_mode have no effect on a running transfer.
- R11: done is a one-cycle pulse in the first cycle after busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_valid | input | 1 | A command is being presented this cycle |
| cmd_code | input | 8 | Command code (8'hA5 = write byte) |
| cmd_data | input | 8 | Data byte to transmit |
| fast_mode | input | 1 | Speed select, latched at acceptance |
| line_in | input | 1 | Raw level of the one-wire line |
| cmd_ack | output | 1 | Command accepted (combinational) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when busy falls |
| drive_low | output | 1 | Open-drain pull-down enable for the line |
| rx_byte | output | 8 | Sampled line bits, LSB first |

## Verification
The bench builds the engine with short timings: SLOT 20, LOW0 14, LOW1 2 and SAMP 6 for standard speed, and SLOT 8, LOW0 5, LOW1 1 and SAMP 4 for fast speed. With these values a full byte takes 160 or 64 cycles, so a model on every clock can cover many bytes, both speeds, a command rejected mid-transfer and a wrong code within a short run. The values keep SAMP − 2 at or after the end of a 1 low phase and inside a 0 low phase. This exercises the synchronizer delay and makes the result of a slave that answers 0 visible in rx_byte.

// File: rtl/ow_pkg.sv
package ow_pkg;
  localparam logic [7:0] OW_CMD_WRBYTE = 8'hA5;
  localparam int         OW_BITS       = 8;

  typedef enum logic {
    SPD_STD  = 1'b0,
    SPD_FAST = 1'b1
  } ow_speed_e;
endpackage

// File: rtl/ow_line_sync.sv
module ow_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], raw_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/ow_slot_timer.sv
module ow_slot_timer
  import ow_pkg::*;
#(
  parameter int SLOT_STD  = 7000,
  parameter int SLOT_FAST = 1000,
  parameter int BITS      = 8,
  parameter int CW        = 13,
  localparam int BW       = $clog2(BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          fast_in,
  output logic          busy,
  output ow_speed_e     speed,
  output logic [CW-1:0] cnt,
  output logic          slot_end,
  output logic          done
);
  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [BW-1:0] bit_q, bit_d;
  ow_speed_e     spd_q, spd_d;
  logic          done_q, done_d;
  logic [CW-1:0] slot_last;

  assign slot_last = (spd_q == SPD_FAST) ? CW'(SLOT_FAST - 1) : CW'(SLOT_STD - 1);
  assign slot_end  = busy_q && (cnt_q == slot_last);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    spd_d  = spd_q;
    done_d = 1'b0;
    if (busy_q) begin
      if (slot_end) begin
        cnt_d = '0;
        if (bit_q == BW'(BITS - 1)) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end else begin
          bit_d = bit_q + 1'b1;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      bit_d  = '0;
      spd_d  = fast_in ? SPD_FAST : SPD_STD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      bit_q  <= '0;
      spd_q  <= SPD_STD;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      spd_q  <= spd_d;
      done_q <= done_d;
    end
  end

  assign busy  = busy_q;
  assign speed = spd_q;
  assign cnt   = cnt_q;
  assign done  = done_q;
endmodule

// File: rtl/ow_bit_shifter.sv
module ow_bit_shifter #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [BITS-1:0] load_data,
  input  logic            advance,
  input  logic            capture,
  input  logic            sample_bit,
  output logic            tx_bit,
  output logic [BITS-1:0] rx_data
);
  logic [BITS-1:0] tx_q, tx_d;
  logic [BITS-1:0] rx_q, rx_d;

  always_comb begin
    tx_d = tx_q;
    if (load)         tx_d = load_data;
    else if (advance) tx_d = {1'b0, tx_q[BITS-1:1]};
  end

  always_comb begin
    rx_d = rx_q;
    if (capture) rx_d = {sample_bit, rx_q[BITS-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end

  assign tx_bit  = tx_q[0];
  assign rx_data = rx_q;
endmodule

// File: rtl/ow_byte_slot_engine.sv
module ow_byte_slot_engine
  import ow_pkg::*;
#(
  parameter int SLOT_STD  = 7000,
  parameter int LOW0_STD  = 6000,
  parameter int LOW1_STD  = 600,
  parameter int SAMP_STD  = 1500,
  parameter int SLOT_FAST = 1000,
  parameter int LOW0_FAST = 750,
  parameter int LOW1_FAST = 100,
  parameter int SAMP_FAST = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_code,
  input  logic [7:0] cmd_data,
  input  logic       fast_mode,
  input  logic       line_in,
  output logic       cmd_ack,
  output logic       busy,
  output logic       done,
  output logic       drive_low,
  output logic [7:0] rx_byte
);
  localparam int SLOT_MAX = (SLOT_STD > SLOT_FAST) ? SLOT_STD : SLOT_FAST;
  localparam int CW       = $clog2(SLOT_MAX + 1);

  ow_speed_e     speed;
  logic [CW-1:0] cnt;
  logic          slot_end;
  logic          tx_bit;
  logic          line_s;
  logic          start;
  logic          capture;
  logic [CW-1:0] low_len;
  logic [CW-1:0] samp_at;

  assign start   = cmd_valid && (cmd_code == OW_CMD_WRBYTE) && !busy;
  assign cmd_ack = start;

  always_comb begin
    if (speed == SPD_FAST) begin
      low_len = tx_bit ? CW'(LOW1_FAST) : CW'(LOW0_FAST);
      samp_at = CW'(SAMP_FAST);
    end else begin
      low_len = tx_bit ? CW'(LOW1_STD) : CW'(LOW0_STD);
      samp_at = CW'(SAMP_STD);
    end
  end

  assign drive_low = busy && (cnt < low_len);
  assign capture   = busy && (cnt == samp_at);

  ow_slot_timer #(
    .SLOT_STD (SLOT_STD),
    .SLOT_FAST(SLOT_FAST),
    .BITS     (OW_BITS),
    .CW       (CW)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .fast_in (fast_mode),
    .busy    (busy),
    .speed   (speed),
    .cnt     (cnt),
    .slot_end(slot_end),
    .done    (done)
  );

  ow_line_sync #(.STAGES(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .raw_in  (line_in),
    .sync_out(line_s)
  );

  ow_bit_shifter #(.BITS(OW_BITS)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start),
    .load_data (cmd_data),
    .advance   (slot_end),
    .capture   (capture),
    .sample_bit(line_s),
    .tx_bit    (tx_bit),
    .rx_data   (rx_byte)
  );
endmodule

// File: rtl/ow_byte_slot_engine_chk.sv
module ow_byte_slot_engine_chk #(
  parameter int SLOT_STD  = 7000,
  parameter int LOW0_STD  = 6000,
  parameter int LOW1_STD  = 600,
  parameter int SAMP_STD  = 1500,
  parameter int SLOT_FAST = 1000,
  parameter int LOW0_FAST = 750,
  parameter int LOW1_FAST = 100,
  parameter int SAMP_FAST = 200
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [7:0] cmd_code,
  input logic       fast_mode,
  input logic       cmd_ack,
  input logic       busy,
  input logic       done,
  input logic       drive_low,
  input logic [7:0] rx_byte
);
  logic [31:0] run_cnt;
  logic        run_fast;
  logic [31:0] run_expect;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt  <= '0;
      run_fast <= 1'b0;
    end else if (cmd_ack) begin
      run_cnt  <= '0;
      run_fast <= fast_mode;
    end else if (busy) begin
      run_cnt  <= run_cnt + 1'b1;
    end
  end

  assign run_expect = run_fast ? 32'(8 * SLOT_FAST) : 32'(8 * SLOT_STD);

  p_ack_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ack |=> (busy && drive_low));

  p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_cnt == run_expect));

  p_idle_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !drive_low);

  p_rx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> $stable(rx_byte));

  p_no_ack_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ack);

  p_no_ack_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code != 8'hA5) |-> !cmd_ack);

  p_done_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind ow_byte_slot_engine ow_byte_slot_engine_chk #(
  .SLOT_STD (SLOT_STD),
  .LOW0_STD (LOW0_STD),
  .LOW1_STD (LOW1_STD),
  .SAMP_STD (SAMP_STD),
  .SLOT_FAST(SLOT_FAST),
  .LOW0_FAST(LOW0_FAST),
  .LOW1_FAST(LOW1_FAST),
  .SAMP_FAST(SAMP_FAST)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_valid(cmd_valid),
  .cmd_code (cmd_code),
  .fast_mode(fast_mode),
  .cmd_ack  (cmd_ack),
  .busy     (busy),
  .done     (done),
  .drive_low(drive_low),
  .rx_byte  (rx_byte)
);

// File: tb/ow_byte_slot_engine_test.sv
`timescale 1ns/1ps
module ow_byte_slot_engine_test;
  localparam int S_SLOT = 20, S_L0 = 14, S_L1 = 2, S_SMP = 6;
  localparam int F_SLOT = 8,  F_L0 = 5,  F_L1 = 1, F_SMP = 4;

  logic       clk;
  logic       rst_n;
  logic       cmd_valid;
  logic [7:0] cmd_code;
  logic [7:0] cmd_data;
  logic       fast_mode;
  logic       slave_low;
  logic       line_in;
  logic       cmd_ack;
  logic       busy;
  logic       done;
  logic       drive_low;
  logic [7:0] rx_byte;

  int n_chk;
  int n_fail;
  bit finished;

  // model state
  bit       m_busy, m_done, m_fast, s1, s2;
  int       m_cnt, m_bit;
  bit [7:0] m_data, m_rx, m_slave;

  assign line_in = !(drive_low || slave_low);

  ow_byte_slot_engine #(
    .SLOT_STD(S_SLOT), .LOW0_STD(S_L0), .LOW1_STD(S_L1), .SAMP_STD(S_SMP),
    .SLOT_FAST(F_SLOT), .LOW0_FAST(F_L0), .LOW1_FAST(F_L1), .SAMP_FAST(F_SMP)
  ) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_data(cmd_data), .fast_mode(fast_mode), .line_in(line_in),
    .cmd_ack(cmd_ack), .busy(busy), .done(done), .drive_low(drive_low),
    .rx_byte(rx_byte)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int slot_len();  return m_fast ? F_SLOT : S_SLOT; endfunction
  function automatic int samp_pt();   return m_fast ? F_SMP  : S_SMP;  endfunction
  function automatic bit model_drive();
    int low;
    if (!m_busy) return 1'b0;
    low = m_data[m_bit] ? (m_fast ? F_L1 : S_L1) : (m_fast ? F_L0 : S_L0);
    return m_cnt < low;
  endfunction

  // one clock: apply inputs, check ack, advance model, compare after edge
  task automatic step(input bit v, input bit [7:0] code, input bit [7:0] data, input bit f);
    bit acc, line, d_next;
    cmd_valid = v; cmd_code = code; cmd_data = data; fast_mode = f;
    slave_low = m_busy && !m_slave[m_bit] && (m_cnt < samp_pt() + 3);
    acc = v && (code == 8'hA5) && !m_busy;
    #1;
    check(cmd_ack == acc, "R2 R8 R9 cmd_ack", int'(cmd_ack), int'(acc));
    line = !(model_drive() || slave_low);
    if (m_busy && m_cnt == samp_pt()) m_rx = {s2, m_rx[7:1]};
    d_next = 1'b0;
    if (m_busy) begin
      if (m_cnt == slot_len() - 1) begin
        m_cnt = 0;
        if (m_bit == 7) begin m_busy = 1'b0; d_next = 1'b1; end
        else m_bit++;
      end else m_cnt++;
    end else if (acc) begin
      m_busy = 1'b1; m_cnt = 0; m_bit = 0; m_data = data; m_fast = f;
    end
    s2 = s1; s1 = line; m_done = d_next;
    @(negedge clk);
    check(busy == m_busy, "R2 R3 R10 busy", int'(busy), int'(m_busy));
    check(drive_low == model_drive(), "R4 R5 R6 R10 drive_low", int'(drive_low), int'(model_drive()));
    check(done == m_done, "R11 done", int'(done), int'(m_done));
    check(rx_byte == m_rx, "R7 rx_byte", int'(rx_byte), int'(m_rx));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00, 8'h00, 1'b0);
  endtask

  // full transfer; poke_at >= 0 issues a second write-byte while busy
  task automatic xfer(input bit [7:0] data, input bit [7:0] slave, input bit f, input int poke_at);
    int n;
    m_slave = slave;
    step(1'b1, 8'hA5, data, f);
    n = 0;
    while (m_busy) begin
      if (n == poke_at) step(1'b1, 8'hA5, ~data, ~f);
      else              step(1'b0, 8'h00, 8'h00, ~f);
      n++;
    end
    idle(3);
    check(rx_byte == (data & slave), "R4 R7 final rx_byte", int'(rx_byte), int'(data & slave));
  endtask

  initial begin
    n_chk = 0; n_fail = 0; finished = 1'b0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_code = '0; cmd_data = '0;
    fast_mode = 1'b0; slave_low = 1'b0;
    m_busy = 0; m_done = 0; m_fast = 0; s1 = 1; s2 = 1;
    m_cnt = 0; m_bit = 0; m_data = '0; m_rx = '0; m_slave = 8'hFF;
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && drive_low == 1'b0 && done == 1'b0 && rx_byte == 8'h00,
          "R1 reset state", int'({busy, drive_low, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && drive_low == 1'b0 && rx_byte == 8'h00, "R1 after release",
          int'({busy, drive_low}), 0);
    idle(2);
    xfer(8'h5A, 8'hFF, 1'b0, -1);   // R4 R5 R6 pure write
    xfer(8'hFF, 8'h3C, 1'b0, -1);   // R7 read via 1 slots
    xfer(8'h81, 8'hF0, 1'b1, -1);   // R10 fast speed
    xfer(8'h00, 8'hFF, 1'b1, -1);   // R5 all zero slots, fast
    xfer(8'hC3, 8'hA5, 1'b0, 37);   // R8 reject while busy
    step(1'b1, 8'h3C, 8'h77, 1'b0); // R9 wrong code when idle
    check(busy == 1'b0 && rx_byte == 8'h81, "R9 wrong code ignored", int'(busy), 0);
    idle(4);
    xfer(8'hE7, 8'h5F, 1'b1, 9);    // R8 R10 reject in fast mode
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule